// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Array

This block evaluates a set of Boolean functions held in loadable configuration storage. It has a programmable AND stage that forms a small number of shared product terms from the primary inputs and their complements. A programmable OR stage gathers any subset of those products into each output. A last stage conditionally inverts each output.

Software computes minimized product terms and writes them word by word into the configuration storage. It then holds the lock input high so that the evaluated functions cannot change. The outputs are purely combinational in the inputs and the stored configuration.

The storage holds exactly 2·N·P + P·M + 2·M bits for N inputs, P products and M outputs. With the defaults (N=4, P=6, M=3) that is 72 bits, written as nine 8-bit words.

Top module: `pla_core`

## Requirements
- R1: Reset is synchronous and active high. It clears every configuration bit, so all outputs read 0 for every input value after reset.
- R2: Configuration bit k·2N + 2i, when set, connects input i in true form to product k. Bit k·2N + 2i + 1, when set, connects the complement of input i to product k. A product is the AND of its connected literals.
- R3: A product with no connected literal evaluates to 1.
- R4: A product connected to both the true and the complement form of the same input evaluates to 0.
- R5: Configuration bit 2NP + j·P + k, when set, feeds product k into output j. Output j before polarity is the OR of its fed products. With no fed products it is 0.
- R6: Output j has two polarity bits: the tie-low bit at 2NP + PM + 2j and the tie-high bit at 2NP + PM + 2j + 1. The output is inverted only when the tie-high bit is set and the tie-low bit is clear. When both bits are set, tie-low wins and the output is not inverted.
- R7: A write with cfg_we high and cfg_lock low at a rising clock edge stores cfg_data into bits [a·W +: W], where a is the word address and W is the word width. The outputs show the new configuration from that edge onward and the old one before it.
- R8: While cfg_lock is high, writes leave the configuration and outputs unchanged.
- R9: A write to an address at or beyond the word count (9 with the defaults) leaves the configuration and outputs unchanged.
- R10: A single product may feed several outputs at once, and each output sees its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_lock | input | 1 | When high, all writes are blocked |
| cfg_addr | input | CFG_AW (4) | Configuration word address |
| cfg_data | input | CFG_W (8) | Configuration word data |
| in_vec | input | N_IN (4) | Primary inputs, bit i is input i |
| out_vec | output | N_OUT (3) | Evaluated outputs, bit j is output j |

## Verification
The assertions assume that the configuration inputs are stable around the rising edge. The bench meets this by driving them only on falling edges. The combinational checks in the AND and OR stages assume that a fully known configuration word is written. The bench therefore writes every word from a fully defined shadow image before it samples any output. The lock and range checks assume that only cfg_we qualifies a write. The stimulus accordingly pairs each blocked write with a strobe that would otherwise land, and compares the outputs before and after it.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Polarity link pair of one output; tie_zero sits at the lower bit.
    typedef struct packed {
        logic tie_one;
        logic tie_zero;
    } pol_link_t;

    function automatic int cfg_total(input int n, input int p, input int m);
        return 2 * n * p + p * m + 2 * m;
    endfunction

    function automatic int cfg_words(input int total, input int w);
        return (total + w - 1) / w;
    endfunction

    // Ground link dominates: inversion only with the high link alone.
    function automatic logic pol_invert(input pol_link_t l);
        return l.tie_one & ~l.tie_zero;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int TOTAL = 72,
    parameter int W     = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             lock,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     data,
    output logic [TOTAL-1:0] cfg_q
);
    localparam int WORDS  = pla_pkg::cfg_words(TOTAL, W);
    localparam int PADDED = WORDS * W;

    logic [PADDED-1:0] img_q;
    logic              wr_ok;

    assign wr_ok = we && !lock && (32'(addr) < WORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
        end else if (wr_ok) begin
            img_q[32'(addr) * W +: W] <= data;
        end
    end

    assign cfg_q = img_q[TOTAL-1:0];

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (img_q == '0));
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (we && lock) |=> $stable(img_q));
    p_range_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (we && (32'(addr) >= WORDS)) |=> $stable(img_q));
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (we && !lock && (32'(addr) < WORDS)) |=>
        (img_q[32'($past(addr)) * W +: W] == $past(data)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N = 4,
    parameter int P = 6
) (
    input  logic [N-1:0]     in_vec,
    input  logic [2*N*P-1:0] and_cfg,
    output logic [P-1:0]     term
);
    localparam int ROW = 2 * N;

    for (genvar k = 0; k < P; k++) begin : g_term
        logic [ROW-1:0] row;
        logic [N-1:0]   use_t;
        logic [N-1:0]   use_c;
        logic           acc;

        assign row = and_cfg[k*ROW +: ROW];

        always_comb begin
            acc = 1'b1;
            for (int i = 0; i < N; i++) begin
                use_t[i] = row[2*i];
                use_c[i] = row[2*i+1];
                if (use_t[i]) acc = acc & in_vec[i];
                if (use_c[i]) acc = acc & ~in_vec[i];
            end
        end

        assign term[k] = acc;

        always_comb begin
            if (row == '0)
                p_empty_term_r3: assert (term[k] == 1'b1);
            if ((use_t & use_c) != '0)
                p_conflict_zero_r4: assert (term[k] == 1'b0);
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int P = 6,
    parameter int M = 3
) (
    input  logic [P-1:0]   term,
    input  logic [P*M-1:0] or_cfg,
    input  logic [2*M-1:0] pol_cfg,
    output logic [M-1:0]   out_vec
);
    for (genvar j = 0; j < M; j++) begin : g_out
        logic [P-1:0] sel;
        pol_link_t    link;
        logic         sum;

        assign sel  = or_cfg[j*P +: P];
        assign link = pol_link_t'(pol_cfg[2*j +: 2]);
        assign sum  = |(term & sel);
        assign out_vec[j] = sum ^ pol_invert(link);

        always_comb begin
            if (sel == '0)
                p_empty_or_r5: assert (out_vec[j] == (link.tie_one & ~link.tie_zero));
            if (link.tie_zero)
                p_ground_wins_r6: assert (out_vec[j] == sum);
        end
    end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int N_IN  = 4,
    parameter int N_PT  = 6,
    parameter int N_OUT = 3,
    parameter int CFG_W = 8,
    localparam int CFG_TOTAL = pla_pkg::cfg_total(N_IN, N_PT, N_OUT),
    localparam int CFG_WORDS = pla_pkg::cfg_words(CFG_TOTAL, CFG_W),
    localparam int CFG_AW    = $clog2(CFG_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_lock,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);
    localparam int AND_BITS = 2 * N_IN * N_PT;
    localparam int OR_BITS  = N_PT * N_OUT;
    localparam int POL_BITS = 2 * N_OUT;

    logic [CFG_TOTAL-1:0] cfg_q;
    logic [N_PT-1:0]      term;

    pla_cfg_store #(.TOTAL(CFG_TOTAL), .W(CFG_W), .AW(CFG_AW)) store_i (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .lock (cfg_lock),
        .addr (cfg_addr),
        .data (cfg_data),
        .cfg_q(cfg_q)
    );

    pla_and_plane #(.N(N_IN), .P(N_PT)) and_i (
        .in_vec (in_vec),
        .and_cfg(cfg_q[AND_BITS-1:0]),
        .term   (term)
    );

    pla_or_plane #(.P(N_PT), .M(N_OUT)) or_i (
        .term   (term),
        .or_cfg (cfg_q[AND_BITS +: OR_BITS]),
        .pol_cfg(cfg_q[AND_BITS+OR_BITS +: POL_BITS]),
        .out_vec(out_vec)
    );

    p_reset_outputs_r1: assert property (@(posedge clk) rst |=> (out_vec == '0));

endmodule

// File: tb/pla_core_tb_top.sv
module pla_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_lock = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic [3:0] in_vec = '0;
    logic [2:0] out_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [71:0] img = '0;

    // Expected {O2,O1,O0} indexed by {C,B,A}; input D is unused.
    localparam logic [2:0] EXP_TBL [8] = '{3'b110, 3'b010, 3'b110, 3'b001,
                                           3'b010, 3'b101, 3'b010, 3'b101};

    always #2 clk = ~clk;

    pla_core dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lock(cfg_lock),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_vec(in_vec), .out_vec(out_vec)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (out_vec !== exp) begin
            n_fail++;
            $display("FAIL %s in=%b got=%b exp=%b", req, in_vec, out_vec, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v, input string req, input logic [2:0] exp);
        @(negedge clk);
        in_vec = v;
        #1;
        check(req, exp);
    endtask

    task automatic put_lit(input int k, input int i, input int comp);
        img[k*8 + 2*i + comp] = 1'b1;
    endtask

    task automatic put_or(input int j, input int k);
        img[48 + j*6 + k] = 1'b1;
    endtask

    task automatic put_pol(input int j, input int high);
        img[66 + 2*j + high] = 1'b1;
    endtask

    task automatic write_word(input int a, input logic [7:0] d, input logic lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = d; cfg_lock = lk;
        @(negedge clk);
        cfg_we = 1'b0; cfg_lock = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared configuration gives all-zero outputs
        apply(4'd0,  "R1", 3'b000);
        apply(4'd15, "R1", 3'b000);

        // P0=AB, P1=AC, P2=ABC, P3=~A~C, P4=B&~B, P5 empty
        put_lit(0, 0, 0); put_lit(0, 1, 0);
        put_lit(1, 0, 0); put_lit(1, 2, 0);
        put_lit(2, 0, 0); put_lit(2, 1, 0); put_lit(2, 2, 0);
        put_lit(3, 0, 1); put_lit(3, 2, 1);
        put_lit(4, 1, 0); put_lit(4, 1, 1);
        put_or(0, 0); put_or(0, 1); put_or(0, 2); put_pol(0, 0);
        put_or(1, 0); put_or(1, 1); put_or(1, 2); put_pol(1, 1);
        put_or(2, 1); put_or(2, 3); put_or(2, 4); put_pol(2, 0); put_pol(2, 1);
        for (int a = 0; a < 9; a++) write_word(a, img[a*8 +: 8], 1'b0);

        // R2 R4 R5 R6 R10: F1, its complement, and a shared-term XNOR
        for (int v = 0; v < 16; v++) apply(4'(v), "R2/R4/R5/R6/R10", EXP_TBL[v % 8]);

        // R7: word 8 holds the polarity bits; clear the O1 tie-high link
        img[69] = 1'b0;
        @(negedge clk);
        in_vec = 4'd0;
        cfg_we = 1'b1; cfg_addr = 4'd8; cfg_data = img[64 +: 8]; cfg_lock = 1'b0;
        #1;
        check("R7 before edge", 3'b110);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R7 after edge", 3'b100);
        img[69] = 1'b1;
        write_word(8, img[64 +: 8], 1'b0);
        apply(4'd0, "R7 restore", 3'b110);

        // R8: locked write of zeros to the polarity word has no effect
        write_word(8, 8'h00, 1'b1);
        apply(4'd0, "R8", 3'b110);
        apply(4'd5, "R8", 3'b101);

        // R9: out-of-range addresses are ignored
        write_word(9, 8'hFF, 1'b0);
        write_word(15, 8'hFF, 1'b0);
        apply(4'd0, "R9", 3'b110);
        apply(4'd3, "R9", 3'b001);

        // R3: feed the empty product P5 into O0, which then reads 1
        put_or(0, 5);
        write_word(6, img[48 +: 8], 1'b0);
        apply(4'd0, "R3", 3'b111);
        apply(4'd6, "R3", 3'b011);

        done = 1'b1;
        report();
    end

endmodule